// File: doc/BRIEF.md
# Rotated complex multiply-accumulate unit

This block is a vector datapath that reads a wide register as a row of interleaved complex numbers and performs one step of a complex multiply-accumulate. The caller supplies two multiplicand vectors, an accumulator vector, a byte-granular predicate, an element-size code and a 2-bit rotation code. The unit returns the updated accumulator one cycle after it accepts the operation. Each lane uses signed fixed-point arithmetic.

For every complex pair, one component of the first multiplicand is multiplied by a component of the second multiplicand. That second component is picked and sign-adjusted by the rotation. The product is added into the matching accumulator lane. Two calls on the same operands, with rotations a quarter turn apart, together form a complete complex multiply-add or multiply-subtract. A predicate bit masks each lane on its own.

Operations enter through a valid/ready handshake. The result sits in a single output register, which holds its value until the consumer takes it.

Top module: `cplx_rot_mac`

## Requirements
- R1: Each complex number is an element pair: the real part is the even element (lower address) and the imaginary part is the odd element. With rotation code 2'b00 (0°), real += a_re·b_re and imag += a_re·b_im.
- R2: With rotation code 2'b01 (90°), real += −(a_im·b_im) and imag += a_im·b_re.
- R3: With rotation code 2'b10 (180°), real += −(a_re·b_re) and imag += −(a_re·b_im).
- R4: With rotation code 2'b11 (270°), real += a_im·b_im and imag += −(a_im·b_re).
- R5: Size code 2'b01 selects 16-bit elements, 2'b10 selects 32-bit elements and 2'b11 selects 64-bit elements. Every lane is two's complement and keeps only the low element-width bits of the sum, with wrap-around. Negating the most negative value gives the same value back.
- R6: Predicate bit k covers byte k. The bit of an element's lowest byte gates that element. An inactive element returns its accumulator value unchanged. When no element is active, the whole output equals the accumulator input.
- R7: Size code 2'b00 is illegal. The result carries `illegal`=1 and returns the accumulator input unchanged. Legal codes return `illegal`=0.
- R8: `in_ready` = !`out_valid` || `out_ready`. An operation accepted at a clock edge produces `out_valid`=1 with its result after that same edge. While `out_valid`=1 and `out_ready`=0, `out_valid` and `acc_out` hold.
- R9: A pass at 0° followed by a pass at 90°, where the second pass uses the first result as its accumulator, yields acc + a·b as a complex product.
- R10: After reset, `out_valid` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| src_a | input | VEC_W | First multiplicand vector |
| src_b | input | VEC_W | Second multiplicand vector |
| acc_in | input | VEC_W | Accumulator (addend) vector |
| pred | input | VEC_W/8 | Per-byte predicate |
| esize | input | 2 | Element-size code |
| rot | input | 2 | Rotation code |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| acc_out | output | VEC_W | Updated accumulator vector |
| illegal | output | 1 | Result came from the reserved size code |

## Verification
All four rotations run at all three element sizes with random full-width operands and a fully set predicate, which separates the component selection from the sign control in each lane. Vectors filled with the most negative value show the wrap of negation and truncation. Predicate patterns that set only the bytes that are not lowest bytes, along with empty and random masks, show that gating follows the lowest byte of each element. A stalled consumer, an alternating ready, the reserved size code and a chained 0°/90° pair cover the handshake, the illegal path and the composed complex product.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic [1:0] {
        ESZ_RSV = 2'b00,
        ESZ_16  = 2'b01,
        ESZ_32  = 2'b10,
        ESZ_64  = 2'b11
    } esz_e;

    localparam int NUM_SIZES = 3;

    function automatic int lane_bits(input int idx);
        return 16 << idx;
    endfunction

endpackage

// File: rtl/cmac_pair.sv
module cmac_pair #(
    parameter int ES = 16
) (
    input  logic [ES-1:0] n_re,
    input  logic [ES-1:0] n_im,
    input  logic [ES-1:0] m_re,
    input  logic [ES-1:0] m_im,
    input  logic [ES-1:0] c_re,
    input  logic [ES-1:0] c_im,
    input  logic          act_re,
    input  logic          act_im,
    input  logic [1:0]    rot,
    output logic [ES-1:0] r_re,
    output logic [ES-1:0] r_im
);
    logic [ES-1:0] a_pick;
    logic [ES-1:0] b_re_raw, b_im_raw;
    logic [ES-1:0] b_re, b_im;
    logic [ES-1:0] p_re, p_im;

    always_comb begin
        // odd rotations take the imaginary part of the first operand
        a_pick   = rot[0] ? n_im : n_re;
        b_re_raw = rot[0] ? m_im : m_re;
        b_im_raw = rot[0] ? m_re : m_im;
        b_re     = (rot[0] ^ rot[1]) ? (ES'(0) - b_re_raw) : b_re_raw;
        b_im     = rot[1]            ? (ES'(0) - b_im_raw) : b_im_raw;
        // low half of the signed product equals the low half of the unsigned one
        p_re     = a_pick * b_re;
        p_im     = a_pick * b_im;
        r_re     = act_re ? (c_re + p_re) : c_re;
        r_im     = act_im ? (c_im + p_im) : c_im;
    end

endmodule

// File: rtl/cmac_bank.sv
module cmac_bank #(
    parameter int VEC_W = 256,
    parameter int ES    = 16
) (
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   acc_in,
    input  logic [VEC_W/8-1:0] pred,
    input  logic [1:0]         rot,
    output logic [VEC_W-1:0]   res
);
    localparam int NE  = VEC_W / ES;
    localparam int NP  = NE / 2;
    localparam int BPE = ES / 8;

    logic [NE-1:0]    gov;
    logic             any_on;
    logic [VEC_W-1:0] op_a, op_b;
    logic             unused_pred;

    assign unused_pred = ^pred;

    for (genvar e = 0; e < NE; e++) begin : g_gov
        assign gov[e] = pred[e*BPE];
    end

    assign any_on = |gov;
    assign op_a   = any_on ? src_a : '0;
    assign op_b   = any_on ? src_b : '0;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        cmac_pair #(.ES(ES)) u_pair (
            .n_re   (op_a  [(2*p)*ES   +: ES]),
            .n_im   (op_a  [(2*p+1)*ES +: ES]),
            .m_re   (op_b  [(2*p)*ES   +: ES]),
            .m_im   (op_b  [(2*p+1)*ES +: ES]),
            .c_re   (acc_in[(2*p)*ES   +: ES]),
            .c_im   (acc_in[(2*p+1)*ES +: ES]),
            .act_re (gov[2*p]),
            .act_im (gov[2*p+1]),
            .rot    (rot),
            .r_re   (res[(2*p)*ES   +: ES]),
            .r_im   (res[(2*p+1)*ES +: ES])
        );
    end

endmodule

// File: rtl/cplx_rot_mac.sv
module cplx_rot_mac
    import cmac_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   acc_in,
    input  logic [VEC_W/8-1:0] pred,
    input  logic [1:0]         esize,
    input  logic [1:0]         rot,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [VEC_W-1:0]   acc_out,
    output logic               illegal
);
    typedef struct packed {
        logic             vld;
        logic             ill;
        logic [VEC_W-1:0] acc;
    } st_t;

    st_t              st_d, st_q;
    logic             fire;
    logic [VEC_W-1:0] bank_res [NUM_SIZES];
    esz_e             sz;

    assign sz = esz_e'(esize);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
        cmac_bank #(.VEC_W(VEC_W), .ES(lane_bits(g))) u_bank (
            .src_a  (src_a),
            .src_b  (src_b),
            .acc_in (acc_in),
            .pred   (pred),
            .rot    (rot),
            .res    (bank_res[g])
        );
    end

    assign in_ready = !st_q.vld || out_ready;
    assign fire     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (fire) begin
            st_d.vld = 1'b1;
            st_d.ill = (sz == ESZ_RSV);
            unique case (sz)
                ESZ_16:  st_d.acc = bank_res[0];
                ESZ_32:  st_d.acc = bank_res[1];
                ESZ_64:  st_d.acc = bank_res[2];
                default: st_d.acc = acc_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign acc_out   = st_q.acc;
    assign illegal   = st_q.ill;

    AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(acc_out)); // R8
    AST_ILLEGAL_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && esize == 2'b00 |=> illegal && acc_out == $past(acc_in)); // R7
    AST_ALL_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        fire && pred == '0 |=> acc_out == $past(acc_in)); // R6

endmodule

// File: tb/sim_cplx_rot_mac.sv
module sim_cplx_rot_mac;
    localparam int  VW     = 256;
    localparam int  PW     = VW / 8;
    localparam time PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] src_a = '0, src_b = '0, acc_in = '0;
    logic [PW-1:0] pred = '0;
    logic [1:0]    esize = 2'b01, rot = 2'b00;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VW-1:0] acc_out;
    logic          illegal;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    int cyc = 0;

    typedef struct {
        logic          ill;
        logic [VW-1:0] v;
        string         req;
    } exp_t;

    exp_t          q[$];
    logic [VW-1:0] last_out = '0;
    logic [VW-1:0] prev_acc = '0;
    logic          hold_prev = 1'b0;

    cplx_rot_mac #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .pred(pred),
        .esize(esize), .rot(rot), .out_valid(out_valid), .out_ready(out_ready),
        .acc_out(acc_out), .illegal(illegal)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] emask(input int es);
        return (es == 64) ? '1 : ((64'd1 << es) - 64'd1);
    endfunction

    function automatic logic [63:0] gel(input logic [VW-1:0] v, input int idx, input int es);
        logic [VW-1:0] t;
        t = v >> (idx * es);
        return t[63:0] & emask(es);
    endfunction

    function automatic logic [VW-1:0] pel(input logic [VW-1:0] v, input int idx,
                                          input int es, input logic [63:0] x);
        logic [VW-1:0] m, xx;
        m  = {{(VW-64){1'b0}}, emask(es)} << (idx * es);
        xx = {{(VW-64){1'b0}}, x & emask(es)} << (idx * es);
        return (v & ~m) | xx;
    endfunction

    function automatic exp_t model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                   input logic [VW-1:0] c, input logic [PW-1:0] p,
                                   input logic [1:0] sz, input logic [1:0] rt);
        exp_t r;
        int es;
        logic [63:0] x, yr, yi;
        r.ill = (sz == 2'b00);
        r.v   = c;
        r.req = "";
        if (r.ill) return r;
        es = 8 << sz;
        for (int k = 0; k < VW / (2 * es); k++) begin
            x  = rt[0] ? gel(a, 2*k+1, es) : gel(a, 2*k, es);
            yr = rt[0] ? gel(b, 2*k+1, es) : gel(b, 2*k, es);
            yi = rt[0] ? gel(b, 2*k, es)   : gel(b, 2*k+1, es);
            if (rt[0] != rt[1]) yr = -yr;
            if (rt[1])          yi = -yi;
            if (p[(2*k)*es/8])   r.v = pel(r.v, 2*k,   es, gel(c, 2*k,   es) + x * yr);
            if (p[(2*k+1)*es/8]) r.v = pel(r.v, 2*k+1, es, gel(c, 2*k+1, es) + x * yi);
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c,
                        input logic [PW-1:0] p, input logic [1:0] sz, input logic [1:0] rt,
                        input string req);
        exp_t e;
        e = model(a, b, c, p, sz, rt);
        e.req = req;
        @(negedge clk);
        src_a = a; src_b = b; acc_in = c; pred = p; esize = sz; rot = rt;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        q.push_back(e);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        #3;
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        out_ready = (rdy_mode == 0) || (rdy_mode == 1 && cyc[0]);
        #2;
        if (rst_n) begin
            chk("R8 out_valid", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, q.size() != 0});
            chk("R8 in_ready", {{(VW-1){1'b0}}, in_ready}, {{(VW-1){1'b0}}, (!out_valid || out_ready)});
            if (hold_prev) begin
                chk("R8 hold valid", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1});
                chk("R8 hold data", acc_out, prev_acc);
            end
            hold_prev = out_valid && !out_ready;
            prev_acc  = acc_out;
            if (out_valid && out_ready && q.size() != 0) begin
                e = q.pop_front();
                chk(e.req, acc_out, e.v);
                chk({e.req, " illegal"}, {{(VW-1){1'b0}}, illegal}, {{(VW-1){1'b0}}, e.ill});
                last_out = acc_out;
            end
        end
    end

    initial begin
        #(PERIOD * 60000);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [VW-1:0] a, b, c, r1, ex;
        logic [63:0]   are, aim, bre, bim;
        string         rq;

        repeat (4) @(negedge clk);
        #2;
        chk("R10 out_valid", {{(VW-1){1'b0}}, out_valid}, '0);
        chk("R10 illegal", {{(VW-1){1'b0}}, illegal}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1..R4 across every size, full predicate
        for (int sz = 1; sz < 4; sz++) begin
            for (int rt = 0; rt < 4; rt++) begin
                rq = (rt == 0) ? "R1" : (rt == 1) ? "R2" : (rt == 2) ? "R3" : "R4";
                send(rnd_vec(), rnd_vec(), rnd_vec(), '1, 2'(sz), 2'(rt), rq);
            end
        end
        drain();

        // R5: most negative values, wrap on negation and truncation
        for (int sz = 1; sz < 4; sz++) begin
            a = '0; b = '0;
            for (int k = 0; k < VW / (8 << sz); k++) begin
                a = pel(a, k, 8 << sz, 64'h8000_0000_0000_0000 >> (64 - (8 << sz)));
                b = pel(b, k, 8 << sz, 64'h8000_0000_0000_0000 >> (64 - (8 << sz)));
            end
            for (int rt = 0; rt < 4; rt++) send(a, b, rnd_vec(), '1, 2'(sz), 2'(rt), "R5");
            send(rnd_vec(), a, rnd_vec(), '1, 2'(sz), 2'b10, "R5");
        end
        drain();

        // R6: predicate gating by lowest byte
        send(rnd_vec(), rnd_vec(), rnd_vec(), '0, 2'b01, 2'b00, "R6");
        send(rnd_vec(), rnd_vec(), rnd_vec(), {(PW/2){2'b10}}, 2'b01, 2'b01, "R6");
        send(rnd_vec(), rnd_vec(), rnd_vec(), {(PW/4){4'b1110}}, 2'b10, 2'b10, "R6");
        send(rnd_vec(), rnd_vec(), rnd_vec(), {(PW/8){8'h01}}, 2'b11, 2'b11, "R6");
        send(rnd_vec(), rnd_vec(), rnd_vec(), {(PW/4){4'b0001}}, 2'b01, 2'b00, "R6");
        for (int i = 0; i < 6; i++)
            send(rnd_vec(), rnd_vec(), rnd_vec(), PW'($urandom), 2'(1 + i % 3), 2'(i), "R6");
        drain();

        // R7: reserved size code
        send(rnd_vec(), rnd_vec(), rnd_vec(), '1, 2'b00, 2'b00, "R7");
        send(rnd_vec(), rnd_vec(), rnd_vec(), '1, 2'b00, 2'b11, "R7");
        send(rnd_vec(), rnd_vec(), rnd_vec(), '1, 2'b10, 2'b00, "R7");
        drain();

        // R8: alternating ready, then a full stall
        rdy_mode = 1;
        for (int i = 0; i < 6; i++)
            send(rnd_vec(), rnd_vec(), rnd_vec(), '1, 2'(1 + i % 3), 2'(i), "R8");
        drain();
        rdy_mode = 2;
        send(rnd_vec(), rnd_vec(), rnd_vec(), '1, 2'b10, 2'b01, "R8");
        repeat (5) @(negedge clk);
        #3;
        chk("R8 stalled in_ready", {{(VW-1){1'b0}}, in_ready}, '0);
        rdy_mode = 0;
        drain();

        // R9: two passes a quarter turn apart build a full complex product
        for (int t = 0; t < 2; t++) begin
            a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
            send(a, b, c, '1, 2'b10, 2'b00, "R9 first pass");
            drain();
            r1 = last_out;
            send(a, b, r1, '1, 2'b10, 2'b01, "R9 second pass");
            drain();
            ex = c;
            for (int k = 0; k < VW / 64; k++) begin
                are = gel(a, 2*k, 32); aim = gel(a, 2*k+1, 32);
                bre = gel(b, 2*k, 32); bim = gel(b, 2*k+1, 32);
                ex = pel(ex, 2*k,   32, gel(c, 2*k, 32)   + are * bre - aim * bim);
                ex = pel(ex, 2*k+1, 32, gel(c, 2*k+1, 32) + are * bim + aim * bre);
            end
            chk("R9 composed product", last_out, ex);
        end

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule